// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of a single-rank or dual-rank SDR SDRAM. Once reset is released it holds the bus quiet through the power-up settling time. It then performs the start-up sequence: one precharge to every bank, a fixed number of auto-refreshes, and a mode register load whose value comes from static parameters. After that it enters a service loop. A free-running interval timer raises refresh requests. Every spacing rule between commands is counted in clock cycles.

An external read/write engine requests the bus with `bus_req` and keeps it for as long as `bus_gnt` is high. While the bus is granted, the sequencer drives only no-operation on the pins. A due refresh waits until the engine lets go. If the engine keeps the bus long enough that a second refresh interval expires before the first is served, the sequencer issues two refreshes back to back, a full row-cycle apart.

A self-refresh request puts the device to sleep by dropping clock-enable together with the refresh command encoding. When the request is removed, clock-enable rises and the sequencer waits two edges plus one row-cycle time before it accepts new work.

Top module: `sdram_refresh_seq`

## Requirements
- R1: From reset until `T_POWERUP` cycles after reset release, the pins carry only no-operation (CS, RAS, CAS, WE = 0,1,1,1) with CKE high. During reset, `ready` and `bus_gnt` are low.
- R2: The start-up order is one precharge (0,0,1,0 with address bit 10 high), then `INIT_REFS` auto-refreshes (0,0,0,1 with CKE high), then one mode register load (0,0,0,0). The mode load drives bank address 0 and this mode word on the address: bits [2:0] encode the burst length (1,2,4,8 as 0,1,2,3), bit 3 is 1 for interleaved wrap, bits [6:4] hold the CAS latency, and all higher bits are 0.
- R3: Command spacing has minimums: `T_RP` cycles after a precharge, `T_RC` cycles after an auto-refresh, and `T_RSC` cycles after a mode load before the next command.
- R4: `ready` rises exactly `T_RSC` cycles after the mode load. It is high only while the sequencer is idle or has granted the bus. It is low during start-up, refresh, self-refresh and self-refresh exit.
- R5: When the bus is left idle, auto-refreshes occur once per `T_REFI` cycles on average.
- R6: `bus_req` in the idle state is answered with `bus_gnt`. While `bus_gnt` is high, the pins carry no commands, and a refresh that falls due waits until `bus_req` is released.
- R7: If a second refresh interval expires while a refresh is still waiting, two auto-refreshes are issued exactly `T_RC` cycles apart once the bus is free.
- R8: A self-refresh request in the idle state, with no refresh waiting, issues the self-refresh command: CS, RAS and CAS low and WE high, in the same cycle that CKE falls. CKE stays low and no command is issued while the request is held.
- R9: Removing the self-refresh request raises CKE one cycle later. `ready` returns `T_RC`+1 cycles after CKE rises, and no command appears earlier than `T_RC`+2 cycles after CKE rises.
- R10: With several ranks, every rank receives identical chip-select and clock-enable values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | External engine asks to borrow the command bus |
| sr_req | input | 1 | Level request to hold the device in self-refresh |
| bus_gnt | output | 1 | Bus lent to the external engine |
| ready | output | 1 | Sequencer idle or bus lent; device usable |
| sd_cke | output | RANKS | Clock enable per rank |
| sd_cs_n | output | RANKS | Chip select per rank, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | AW | Address (bit 10 = all banks, mode word on load) |
| sd_ba | output | BAW | Bank address |

## Verification
The bench shrinks the timing to a power-up wait of 20 cycles, tRP 3, tRC 5, tRSC 2 and a refresh interval of 60 cycles. At this scale, start-up, ten refresh intervals, a held bus long enough to force the catch-up pair, and a full self-refresh entry and exit all fit in a few thousand cycles. It builds two ranks, CAS latency 3, burst length 8 and interleaved wrap, so the mode word is 0x03B and each field has a non-zero value at its position. Every command gap is measured against the minimum for the command that preceded it. Self-refresh exit is treated as a gap event of its own.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    C_NOP, C_PRE, C_REF, C_SELF, C_MRS
  } cmd_e;

  typedef enum logic [3:0] {
    S_PWR, S_PRE_W, S_IREF_W, S_MRS_W, S_IDLE, S_GNT, S_REF_W, S_SR, S_SRX
  } st_e;

  function automatic logic [2:0] burst_code(input int bl);
    case (bl)
      1:       return 3'd0;
      2:       return 3'd1;
      4:       return 3'd2;
      default: return 3'd3;
    endcase
  endfunction

endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int T_REFI = 2080
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ack,
  output logic pend,
  output logic ovr
);
  localparam int W = $clog2(T_REFI + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      pend <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (ack) begin
        pend <= 1'b0;
        ovr  <= 1'b0;
      end
      if (cnt == W'(T_REFI - 1)) begin
        cnt  <= '0;
        pend <= 1'b1;
        if (pend && !ack) ovr <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
  import sdram_seq_pkg::*;
#(
  parameter int T_POWERUP = 13334,
  parameter int T_RP      = 3,
  parameter int T_RC      = 9,
  parameter int T_RSC     = 2,
  parameter int INIT_REFS = 8,
  parameter int CATCHUP   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pend,
  input  logic ovr,
  input  logic bus_req,
  input  logic sr_req,
  output logic ack,
  output logic run,
  output cmd_e cmd,
  output logic cke,
  output logic gnt,
  output logic ready
);
  localparam int WMAX = (T_POWERUP > T_RC) ? T_POWERUP : T_RC;
  localparam int CW   = $clog2(WMAX + 2);
  localparam int RMAX = (INIT_REFS > CATCHUP) ? INIT_REFS : CATCHUP;
  localparam int RW   = $clog2(RMAX + 1);

  st_e           st;
  logic [CW-1:0] w;
  logic [RW-1:0] refs;

  assign ack   = (st == S_IDLE) && pend;
  assign run   = (st == S_IDLE) || (st == S_GNT) || (st == S_REF_W);
  assign ready = (st == S_IDLE) || (st == S_GNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_PWR;
      w    <= CW'(T_POWERUP);
      refs <= '0;
      cmd  <= C_NOP;
      cke  <= 1'b1;
      gnt  <= 1'b0;
    end else begin
      cmd <= C_NOP;
      if (w != '0) w <= w - 1'b1;
      case (st)
        S_PWR: if (w == '0) begin
          cmd <= C_PRE;
          w   <= CW'(T_RP - 1);
          st  <= S_PRE_W;
        end
        S_PRE_W: if (w == '0) begin
          cmd  <= C_REF;
          w    <= CW'(T_RC - 1);
          refs <= RW'(INIT_REFS - 1);
          st   <= S_IREF_W;
        end
        S_IREF_W: if (w == '0) begin
          if (refs != '0) begin
            cmd  <= C_REF;
            refs <= refs - 1'b1;
            w    <= CW'(T_RC - 1);
          end else begin
            cmd <= C_MRS;
            w   <= CW'(T_RSC - 1);
            st  <= S_MRS_W;
          end
        end
        S_MRS_W: if (w == '0) st <= S_IDLE;
        S_IDLE: begin
          if (pend) begin
            cmd  <= C_REF;
            w    <= CW'(T_RC - 1);
            refs <= ovr ? RW'(CATCHUP - 1) : '0;
            st   <= S_REF_W;
          end else if (sr_req) begin
            cmd <= C_SELF;
            cke <= 1'b0;
            st  <= S_SR;
          end else if (bus_req) begin
            gnt <= 1'b1;
            st  <= S_GNT;
          end
        end
        S_REF_W: if (w == '0) begin
          if (refs != '0) begin
            cmd  <= C_REF;
            refs <= refs - 1'b1;
            w    <= CW'(T_RC - 1);
          end else begin
            st <= S_IDLE;
          end
        end
        S_GNT: if (!bus_req) begin
          gnt <= 1'b0;
          st  <= S_IDLE;
        end
        S_SR: if (!sr_req) begin
          cke <= 1'b1;
          w   <= CW'(T_RC);
          st  <= S_SRX;
        end
        S_SRX: if (w == '0) st <= S_IDLE;
        default: st <= S_PWR;
      endcase
    end
  end
endmodule

// File: rtl/sdram_pin_drv.sv
module sdram_pin_drv
  import sdram_seq_pkg::*;
#(
  parameter int          RANKS = 2,
  parameter int          AW    = 12,
  parameter int          BAW   = 2,
  parameter logic [AW-1:0] MODE = '0
) (
  input  cmd_e             cmd,
  input  logic             cke,
  output logic [RANKS-1:0] cke_o,
  output logic [RANKS-1:0] cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [AW-1:0]    addr,
  output logic [BAW-1:0]   ba
);
  localparam logic [AW-1:0] ALL_BANKS = AW'(1) << 10;

  logic sel_n;

  always_comb begin
    sel_n = 1'b0;
    addr  = '0;
    ba    = '0;
    {ras_n, cas_n, we_n} = 3'b111;
    case (cmd)
      C_PRE:  begin {ras_n, cas_n, we_n} = 3'b010; addr = ALL_BANKS; end
      C_REF,
      C_SELF: {ras_n, cas_n, we_n} = 3'b001;
      C_MRS:  begin {ras_n, cas_n, we_n} = 3'b000; addr = MODE; end
      default: ;
    endcase
  end

  for (genvar i = 0; i < RANKS; i++) begin : g_rank
    assign cs_n[i]  = sel_n;
    assign cke_o[i] = cke;
  end
endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import sdram_seq_pkg::*;
#(
  parameter int T_POWERUP       = 13334,
  parameter int T_RP            = 3,
  parameter int T_RC            = 9,
  parameter int T_RSC           = 2,
  parameter int T_REFI          = 2080,
  parameter int INIT_REFS       = 8,
  parameter int RANKS           = 1,
  parameter int AW              = 12,
  parameter int BAW             = 2,
  parameter int CAS_LAT         = 3,
  parameter int BURST_LEN       = 4,
  parameter bit WRAP_INTERLEAVE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_req,
  input  logic             sr_req,
  output logic             bus_gnt,
  output logic             ready,
  output logic [RANKS-1:0] sd_cke,
  output logic [RANKS-1:0] sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [AW-1:0]    sd_addr,
  output logic [BAW-1:0]   sd_ba
);
  localparam logic [AW-1:0] MODE_WORD =
    {{(AW-7){1'b0}}, 3'(CAS_LAT), WRAP_INTERLEAVE, burst_code(BURST_LEN)};

  logic pend, ovr, ack, run, cke;
  cmd_e cmd;

  sdram_ref_timer #(.T_REFI(T_REFI)) u_timer (
    .clk(clk), .rst(rst), .run(run), .ack(ack), .pend(pend), .ovr(ovr)
  );

  sdram_seq_fsm #(
    .T_POWERUP(T_POWERUP), .T_RP(T_RP), .T_RC(T_RC), .T_RSC(T_RSC),
    .INIT_REFS(INIT_REFS), .CATCHUP(2)
  ) u_fsm (
    .clk(clk), .rst(rst), .pend(pend), .ovr(ovr), .bus_req(bus_req),
    .sr_req(sr_req), .ack(ack), .run(run), .cmd(cmd), .cke(cke),
    .gnt(bus_gnt), .ready(ready)
  );

  sdram_pin_drv #(.RANKS(RANKS), .AW(AW), .BAW(BAW), .MODE(MODE_WORD)) u_drv (
    .cmd(cmd), .cke(cke), .cke_o(sd_cke), .cs_n(sd_cs_n), .ras_n(sd_ras_n),
    .cas_n(sd_cas_n), .we_n(sd_we_n), .addr(sd_addr), .ba(sd_ba)
  );
endmodule

// File: rtl/sdram_refresh_seq_chk.sv
module sdram_refresh_seq_chk #(
  parameter int T_POWERUP = 13334,
  parameter int T_RC      = 9,
  parameter int RANKS     = 1,
  parameter int AW        = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_gnt,
  input logic             ready,
  input logic [RANKS-1:0] cke,
  input logic [RANKS-1:0] cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [AW-1:0]    addr
);
  logic [31:0] since_rst;
  logic [15:0] since_ref;
  logic        is_cmd, is_pre, is_ref;

  assign is_cmd = !cs_n[0] && ({ras_n, cas_n, we_n} != 3'b111);
  assign is_pre = !cs_n[0] && ({ras_n, cas_n, we_n} == 3'b010);
  assign is_ref = !cs_n[0] && ({ras_n, cas_n, we_n} == 3'b001);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      since_ref <= '1;
    end else begin
      if (since_rst != '1) since_rst <= since_rst + 1'b1;
      if (is_ref) since_ref <= 16'd1;
      else if (since_ref != '1) since_ref <= since_ref + 1'b1;
    end
  end

  p_quiet_powerup_r1: assert property (@(posedge clk) disable iff (rst)
    (since_rst < 32'(T_POWERUP)) |-> !is_cmd);
  p_prea_all_r2: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> addr[10]);
  p_ref_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    is_ref |-> (since_ref >= 16'(T_RC)));
  p_gnt_ready_r4: assert property (@(posedge clk) disable iff (rst)
    bus_gnt |-> ready);
  p_gnt_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    bus_gnt |-> !is_cmd);
  p_cke_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(cke[0]) |-> is_ref);
  p_rank_match_r10: assert property (@(posedge clk) disable iff (rst)
    (cs_n == {RANKS{cs_n[0]}}) && (cke == {RANKS{cke[0]}}));
endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk #(
  .T_POWERUP(T_POWERUP), .T_RC(T_RC), .RANKS(RANKS), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .bus_gnt(bus_gnt), .ready(ready), .cke(sd_cke),
  .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
  .addr(sd_addr)
);

// File: tb/test_sdram_refresh_seq.sv
`timescale 1ns/1ps
module test_sdram_refresh_seq;
  localparam int TP = 20, TRP = 3, TRC = 5, TRSC = 2, TREFI = 60;
  localparam int RK = 2, AW = 12, BAW = 2;
  localparam logic [AW-1:0] EXP_MODE = 12'h03B;

  logic clk = 1'b0, rst = 1'b1, bus_req = 1'b0, sr_req = 1'b0;
  logic bus_gnt, ready, ras_n, cas_n, we_n;
  logic [RK-1:0] cke, cs_n;
  logic [AW-1:0] addr;
  logic [BAW-1:0] ba;

  sdram_refresh_seq #(
    .T_POWERUP(TP), .T_RP(TRP), .T_RC(TRC), .T_RSC(TRSC), .T_REFI(TREFI),
    .INIT_REFS(8), .RANKS(RK), .AW(AW), .BAW(BAW), .CAS_LAT(3),
    .BURST_LEN(8), .WRAP_INTERLEAVE(1'b1)
  ) i_sdram_refresh_seq (
    .clk(clk), .rst(rst), .bus_req(bus_req), .sr_req(sr_req),
    .bus_gnt(bus_gnt), .ready(ready), .sd_cke(cke), .sd_cs_n(cs_n),
    .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_addr(addr),
    .sd_ba(ba)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int nop_cnt = 0, n_cmds = 0, ref_cnt = 0, rank_err = 0;
  int last_evt = -1, last_min = 0, last_ref = -1;
  int mrs_cyc = -1, first_ready = -1, ready_rise = -1, cke_rise = -1;
  int init_log [10];
  int ref_gap [16];
  logic prev_cke = 1'b1, prev_ready = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int code();
    if (cs_n[0] || {ras_n, cas_n, we_n} == 3'b111) return 0;
    case ({ras_n, cas_n, we_n})
      3'b010:  return 1;
      3'b001:  return cke[0] ? 2 : 3;
      3'b000:  return 4;
      default: return 5;
    endcase
  endfunction

  // command monitor: spacing (R3), order (R2), power-up quiet time (R1)
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      automatic int c = code();
      if (cs_n != {RK{cs_n[0]}} || cke != {RK{cke[0]}}) rank_err++;
      if (cke[0] && !prev_cke) begin
        cke_rise = cyc; last_evt = cyc; last_min = TRC + 2;
      end
      if (ready && !prev_ready) begin
        ready_rise = cyc;
        if (first_ready < 0) first_ready = cyc;
      end
      if (c != 0) begin
        if (n_cmds == 0) chk(nop_cnt >= TP, "R1", "NOP cycles before first command", nop_cnt, TP);
        if (n_cmds < 10) init_log[n_cmds] = c;
        if (last_evt >= 0)
          chk(cyc - last_evt >= last_min, "R3", "command gap", cyc - last_evt, last_min);
        n_cmds++;
        last_evt = cyc;
        case (c)
          1: last_min = TRP;
          2: last_min = TRC;
          4: last_min = TRSC;
          default: last_min = 0;
        endcase
        if (c == 2) begin
          ref_gap[ref_cnt % 16] = (last_ref < 0) ? 0 : cyc - last_ref;
          last_ref = cyc;
          ref_cnt++;
        end
        if (c == 4) begin
          mrs_cyc = cyc;
          chk(addr == EXP_MODE, "R2", "mode word", int'(addr), int'(EXP_MODE));
          chk(ba == '0, "R2", "mode bank address", int'(ba), 0);
        end
      end else if (n_cmds == 0) begin
        nop_cnt++;
      end
      prev_cke = cke[0];
      prev_ready = ready;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    step(1);
    chk(cke == '1, "R1", "CKE in reset", int'(cke), 3);
    chk(code() == 0, "R1", "command in reset", code(), 0);
    chk(!ready && !bus_gnt, "R1", "ready/grant in reset", {ready, bus_gnt}, 0);
  endtask

  task automatic t_init();
    int n = 0;
    while (!ready && n < 500) begin step(1); n++; end
    chk(ready, "R4", "ready after start-up", ready, 1);
    chk(init_log[0] == 1, "R2", "first command is precharge", init_log[0], 1);
    for (int i = 1; i <= 8; i++)
      chk(init_log[i] == 2, "R2", "start-up refresh", init_log[i], 2);
    chk(init_log[9] == 4, "R2", "mode load after refreshes", init_log[9], 4);
    chk(first_ready - mrs_cyc == TRSC, "R4", "ready delay after mode load", first_ready - mrs_cyc, TRSC);
  endtask

  task automatic t_periodic();
    int r0 = ref_cnt;
    step(10 * TREFI);
    chk(ref_cnt - r0 >= 9 && ref_cnt - r0 <= 11, "R5", "refreshes in 10 intervals", ref_cnt - r0, 10);
  endtask

  task automatic t_grant();
    int n = 0, r0, bad = 0, nrdy = 0;
    bus_req = 1'b1;
    while (!bus_gnt && n < TRC * 3 + 4) begin step(1); n++; end
    chk(bus_gnt, "R6", "grant given", bus_gnt, 1);
    r0 = ref_cnt;
    for (int i = 0; i < 70; i++) begin
      step(1);
      if (code() != 0) bad++;
      if (!ready) nrdy++;
    end
    chk(bad == 0, "R6", "commands while granted", bad, 0);
    chk(nrdy == 0, "R4", "ready low while granted", nrdy, 0);
    chk(ref_cnt == r0, "R6", "refresh held off while granted", ref_cnt - r0, 0);
    bus_req = 1'b0;
    step(4);
    chk(!bus_gnt, "R6", "grant released", bus_gnt, 0);
    chk(ref_cnt >= r0 + 1, "R6", "held refresh served", ref_cnt - r0, 1);
    step(3 * TRC);
  endtask

  task automatic t_overrun();
    int n = 0, r0;
    bus_req = 1'b1;
    while (!bus_gnt && n < TRC * 3 + 4) begin step(1); n++; end
    step(2 * TREFI + 10);
    r0 = ref_cnt;
    bus_req = 1'b0;
    step(3 * TRC);
    chk(ref_cnt - r0 >= 2, "R7", "catch-up refresh count", ref_cnt - r0, 2);
    chk(ref_gap[(r0 + 1) % 16] == TRC, "R7", "catch-up refresh spacing", ref_gap[(r0 + 1) % 16], TRC);
    step(2 * TRC);
  endtask

  task automatic t_selfref();
    int n = 0, r0, bad = 0, drop;
    sr_req = 1'b1;
    while (cke[0] && n < 3 * TRC + 4) begin step(1); n++; end
    chk(!cke[0], "R8", "CKE fell", cke[0], 0);
    chk({cs_n[0], ras_n, cas_n, we_n} == 4'b0001, "R8", "self-refresh encoding",
        {cs_n[0], ras_n, cas_n, we_n}, 1);
    r0 = ref_cnt;
    for (int i = 0; i < 200; i++) begin
      step(1);
      if (cke != '0 || code() != 0 || ready) bad++;
    end
    chk(bad == 0, "R8", "quiet, CKE low, ready low in self-refresh", bad, 0);
    chk(ref_cnt == r0, "R8", "no refresh in self-refresh", ref_cnt - r0, 0);
    sr_req = 1'b0;
    drop = cyc;
    step(2 * TRC + 6);
    chk(cke == '1, "R9", "CKE high after exit", int'(cke), 3);
    chk(cke_rise == drop + 1, "R9", "CKE rise latency", cke_rise - drop, 1);
    chk(ready_rise - cke_rise == TRC + 1, "R9", "ready after exit", ready_rise - cke_rise, TRC + 1);
  endtask

  initial begin
    t_reset();
    step(2);
    rst = 1'b0;
    t_init();
    t_periodic();
    t_grant();
    t_overrun();
    t_selfref();
    t_periodic();
    chk(rank_err == 0, "R10", "rank pin mismatches", rank_err, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 60000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule